// File: doc/BRIEF.md
# SD Host Command Issue Sequencer

This block sits between the host's command-register write port and the command-line serializer of an SD host controller. A single write supplies a 16-bit command word, and the block takes a 32-bit argument alongside it. The block decodes the command word, resolves the response kind and data flags, and can look them up in a built-in table of standard commands. It then hands one or more command frames to the serializer over a valid/ready handshake. Application-class commands are preceded by an automatic prefix command. Multi-block transfers are closed by an automatic stop command once the data engine has reported the programmed number of blocks.

Each frame ends with a completion pulse from the serializer, which carries timeout, CRC, end-bit and index-mismatch flags. These flags are folded into a 32-bit error-detail word. Separate bits record the main command path and the automatic stop command. Writes that arrive while a sequence is running, or that carry an illegal field combination, are rejected and raise an illegal-access flag.

The controller states are `ST_IDLE`, `ST_PRE_SEND`, `ST_PRE_WAIT`, `ST_MAIN_SEND`, `ST_MAIN_WAIT`, `ST_BLK_WAIT`, `ST_STOP_SEND` and `ST_STOP_WAIT`. The transitions are as follows:
- From idle, a legal write goes to the prefix send state for application commands and to the main send state otherwise.
- Each send state moves to its wait state when the serializer accepts the frame.
- At the end of the prefix wait, an error returns to idle and success goes to the main send state.
- At the end of the main wait, an error returns to idle. Success on a multi-block data command goes to block counting, and success on anything else returns to idle.
- Block counting moves to the stop send state when the count is reached.
- The stop wait returns to idle on completion.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: In explicit mode (bits 10-8 not 0), the command word fields are passed into the main frame. Bits 5-0 give the index and bits 10-8 give the response code. Bit 11 gives the data flag, bit 12 the direction (1 = read) and bit 13 the multi-block flag. The argument is passed unchanged.
- R2: After reset, `busy`, `frm_valid` and `ila_err` are 0 and `err_detail` reads 0x0000_2000.
- R3: When bits 7-6 equal 1, a prefix frame is sent before the main frame. The prefix frame has index 55, argument `{card_rca,16'h0}` and response code 4.
- R4: If the prefix completes with any error, the main frame is never offered and `busy` drops. The error is recorded in the main-path detail bits.
- R5: After a successful main response on a data command with the multi-block flag, the block counts `blk_done` pulses. When the count reaches `blk_count`, it offers a stop frame: index 12, argument 0, response code 5, `frm_stop`=1. A `blk_count` of 0 behaves as 1.
- R6: In automatic mode (bits 10-8 = 0), the response code and data flags come from a table. The table entries are:
  - index 0: response code 3.
  - indices 2 and 9: response code 6.
  - indices 7 and 12: response code 5.
  - index 17: read, single block.
  - index 18: read, multiple blocks.
  - index 24: write, single block.
  - index 25: write, multiple blocks.
  - application index 41: response code 7.
  - any other index: response code 4 with no data.
- R7: In automatic mode, bits 13-11 of the command word have no effect on the frame.
- R8: A write while `busy` is high sets `ila_err` and is otherwise ignored.
- R9: Writes with certain field combinations set `ila_err` and start nothing. These combinations are:
  - response code 1 or 2;
  - command type 2 or 3;
  - the data flag together with response code 3;
  - the data flag together with a non-application index 12.
- R10: Any write accepted while idle clears `err_detail` to 0x0000_2000 in the following cycle. Bit 13 always reads 1.
- R11: Completion error flags set sticky bits. For the prefix and main frames, timeout sets bit 16, CRC sets bit 8, end-bit sets bit 2 and index mismatch sets bit 0. For the stop frame, the same flags set bits 17, 9, 3 and 1.
- R12: A CRC flag on a frame with response code 7 is ignored.
- R13: `busy` rises in the cycle after an accepted write. It stays high until the last completion of the sequence.
- R14: A frame stays valid and unchanged until `frm_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| arg_wdata | input | 32 | Command argument |
| card_rca | input | 16 | Card address used in the prefix argument |
| blk_count | input | CNT_W | Blocks before the automatic stop |
| blk_done | input | 1 | One pulse per finished data block |
| frm_valid | output | 1 | Frame offered to serializer |
| frm_ready | input | 1 | Serializer accepts frame |
| frm_index | output | 6 | Frame command index |
| frm_arg | output | 32 | Frame argument |
| frm_rsp | output | 3 | Resolved response code |
| frm_data | output | 1 | Frame has a data phase |
| frm_read | output | 1 | Data direction, 1 = read |
| frm_stop | output | 1 | Frame is the automatic stop |
| rsp_done | input | 1 | Completion pulse for the accepted frame |
| rsp_timeout | input | 1 | Response start-bit timeout |
| rsp_crc_err | input | 1 | Response CRC error |
| rsp_end_err | input | 1 | Response end-bit error |
| rsp_idx_err | input | 1 | Response index mismatch |
| busy | output | 1 | Sequence in progress |
| ila_err | output | 1 | Illegal-access flag |
| err_detail | output | 32 | Error-detail word |

## Verification
A write sampled at one clock edge shows its effects one edge later:
- `busy` rises.
- the first frame becomes valid.
- the detail word is cleared.
- `ila_err` is updated.

A `frm_ready` or `rsp_done` sampled at an edge moves the sequence forward and updates the detail word by that same edge. The bench drives every input 1 ns after a rising edge and samples 1 ns after the next one, so each result is read in the first cycle it is due. The bench serializer holds `frm_ready` low for two cycles before accepting, which shows the frame is held stable.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

    localparam int IDX_W = 6;
    localparam int RSP_W = 3;

    localparam logic [IDX_W-1:0] IDX_APP_PREFIX = 6'd55;
    localparam logic [IDX_W-1:0] IDX_STOP       = 6'd12;

    localparam logic [RSP_W-1:0] RSP_AUTO     = 3'd0;
    localparam logic [RSP_W-1:0] RSP_NONE     = 3'd3;
    localparam logic [RSP_W-1:0] RSP_SHORT    = 3'd4;
    localparam logic [RSP_W-1:0] RSP_SHORT_BSY= 3'd5;
    localparam logic [RSP_W-1:0] RSP_LONG     = 3'd6;
    localparam logic [RSP_W-1:0] RSP_NOCRC    = 3'd7;

    localparam int DET_IDX_MAIN = 0;
    localparam int DET_IDX_STOP = 1;
    localparam int DET_END_MAIN = 2;
    localparam int DET_END_STOP = 3;
    localparam int DET_CRC_MAIN = 8;
    localparam int DET_CRC_STOP = 9;
    localparam int DET_FIXED    = 13;
    localparam int DET_TMO_MAIN = 16;
    localparam int DET_TMO_STOP = 17;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [RSP_W-1:0] rsp;
        logic             data;
        logic             read;
        logic             multi;
        logic             app;
    } cmd_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_SEND,
        ST_PRE_WAIT,
        ST_MAIN_SEND,
        ST_MAIN_WAIT,
        ST_BLK_WAIT,
        ST_STOP_SEND,
        ST_STOP_WAIT
    } seq_state_t;

endpackage

// File: rtl/sdcs_decode.sv
module sdcs_decode
    import sdcs_pkg::*;
(
    input  logic [15:0] word,
    output cmd_desc_t   desc,
    output logic        illegal
);

    logic [1:0]       ctype;
    logic [RSP_W-1:0] rfield;
    logic             unused_hi;

    assign ctype     = word[7:6];
    assign rfield    = word[10:8];
    assign unused_hi = ^word[15:14];

    always_comb begin
        desc.idx   = word[5:0];
        desc.app   = (ctype == 2'd1);
        desc.rsp   = RSP_SHORT;
        desc.data  = 1'b0;
        desc.read  = 1'b0;
        desc.multi = 1'b0;
        if (rfield == RSP_AUTO) begin
            if (desc.app) begin
                if (desc.idx == 6'd41) begin
                    desc.rsp = RSP_NOCRC;
                end
            end else begin
                case (desc.idx)
                    6'd0:        desc.rsp = RSP_NONE;
                    6'd2, 6'd9:  desc.rsp = RSP_LONG;
                    6'd7, 6'd12: desc.rsp = RSP_SHORT_BSY;
                    6'd17: begin
                        desc.data = 1'b1;
                        desc.read = 1'b1;
                    end
                    6'd18: begin
                        desc.data  = 1'b1;
                        desc.read  = 1'b1;
                        desc.multi = 1'b1;
                    end
                    6'd24: desc.data = 1'b1;
                    6'd25: begin
                        desc.data  = 1'b1;
                        desc.multi = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else begin
            desc.rsp   = rfield;
            desc.data  = word[11];
            desc.read  = word[12];
            desc.multi = word[13];
        end
    end

    always_comb begin
        illegal = ctype[1]
                | (rfield == 3'd1) | (rfield == 3'd2)
                | (desc.data && (desc.rsp == RSP_NONE))
                | (desc.data && !desc.app && (desc.idx == IDX_STOP));
    end

endmodule

// File: rtl/sdcs_blkcnt.sv
module sdcs_blkcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
    assign hit      = inc && (next_ext >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= next_ext[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/sdcs_errdet.sv
module sdcs_errdet
    import sdcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic        is_stop,
    input  logic        tmo,
    input  logic        crc,
    input  logic        endb,
    input  logic        idxe,
    output logic [31:0] detail
);

    logic [31:0] det_q;
    logic [31:0] set_v;

    always_comb begin
        set_v = '0;
        if (is_stop) begin
            set_v[DET_TMO_STOP] = tmo;
            set_v[DET_CRC_STOP] = crc;
            set_v[DET_END_STOP] = endb;
            set_v[DET_IDX_STOP] = idxe;
        end else begin
            set_v[DET_TMO_MAIN] = tmo;
            set_v[DET_CRC_MAIN] = crc;
            set_v[DET_END_MAIN] = endb;
            set_v[DET_IDX_MAIN] = idxe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            det_q <= '0;
        end else if (upd) begin
            det_q <= det_q | set_v;
        end
    end

    always_comb begin
        detail            = det_q;
        detail[DET_FIXED] = 1'b1;
    end

endmodule

// File: rtl/sdcs_ctrl.sv
module sdcs_ctrl
    import sdcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  cmd_desc_t        desc_in,
    input  logic             illegal,
    input  logic [31:0]      arg_in,
    input  logic [15:0]      card_rca,
    input  logic             frm_ready,
    input  logic             rsp_done,
    input  logic             rsp_timeout,
    input  logic             rsp_crc_err,
    input  logic             rsp_end_err,
    input  logic             rsp_idx_err,
    input  logic             stop_hit,
    input  logic             blk_done,
    output logic             frm_valid,
    output logic [IDX_W-1:0] frm_index,
    output logic [31:0]      frm_arg,
    output logic [RSP_W-1:0] frm_rsp,
    output logic             frm_data,
    output logic             frm_read,
    output logic             frm_stop,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             det_clr,
    output logic             det_upd,
    output logic             det_stop,
    output logic             crc_eff,
    output logic             busy,
    output logic             ila_err
);

    seq_state_t       state_q, state_d;
    cmd_desc_t        desc_q;
    logic [31:0]      arg_q;
    logic             ila_q;
    logic             accept;
    logic             rsp_err;
    logic [RSP_W-1:0] cur_rsp;

    assign accept = cmd_wr && (state_q == ST_IDLE) && !illegal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            arg_q   <= '0;
            ila_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                desc_q <= desc_in;
                arg_q  <= arg_in;
            end
            if (cmd_wr) begin
                ila_q <= (state_q != ST_IDLE) || illegal;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = desc_in.app ? ST_PRE_SEND : ST_MAIN_SEND;
                end
            end
            ST_PRE_SEND: begin
                if (frm_ready) state_d = ST_PRE_WAIT;
            end
            ST_PRE_WAIT: begin
                if (rsp_done) state_d = rsp_err ? ST_IDLE : ST_MAIN_SEND;
            end
            ST_MAIN_SEND: begin
                if (frm_ready) state_d = ST_MAIN_WAIT;
            end
            ST_MAIN_WAIT: begin
                if (rsp_done) begin
                    if (rsp_err) begin
                        state_d = ST_IDLE;
                    end else if (desc_q.data && desc_q.multi) begin
                        state_d = ST_BLK_WAIT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BLK_WAIT: begin
                if (stop_hit) state_d = ST_STOP_SEND;
            end
            ST_STOP_SEND: begin
                if (frm_ready) state_d = ST_STOP_WAIT;
            end
            ST_STOP_WAIT: begin
                if (rsp_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        frm_valid = 1'b0;
        frm_index = desc_q.idx;
        frm_arg   = arg_q;
        frm_rsp   = desc_q.rsp;
        frm_data  = desc_q.data;
        frm_read  = desc_q.read;
        frm_stop  = 1'b0;
        cur_rsp   = desc_q.rsp;
        det_upd   = 1'b0;
        det_stop  = 1'b0;
        cnt_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE_SEND, ST_PRE_WAIT: begin
                frm_valid = (state_q == ST_PRE_SEND);
                frm_index = IDX_APP_PREFIX;
                frm_arg   = {card_rca, 16'h0000};
                frm_rsp   = RSP_SHORT;
                frm_data  = 1'b0;
                frm_read  = 1'b0;
                cur_rsp   = RSP_SHORT;
                det_upd   = (state_q == ST_PRE_WAIT) && rsp_done;
            end
            ST_MAIN_SEND: frm_valid = 1'b1;
            ST_MAIN_WAIT: det_upd = rsp_done;
            ST_BLK_WAIT:  cnt_inc = blk_done;
            ST_STOP_SEND, ST_STOP_WAIT: begin
                frm_valid = (state_q == ST_STOP_SEND);
                frm_index = IDX_STOP;
                frm_arg   = '0;
                frm_rsp   = RSP_SHORT_BSY;
                frm_data  = 1'b0;
                frm_read  = 1'b0;
                frm_stop  = 1'b1;
                cur_rsp   = RSP_SHORT_BSY;
                det_upd   = (state_q == ST_STOP_WAIT) && rsp_done;
                det_stop  = 1'b1;
            end
            default: ;
        endcase
    end

    assign crc_eff = rsp_crc_err && (cur_rsp != RSP_NOCRC);
    assign rsp_err = rsp_timeout || crc_eff || rsp_end_err || rsp_idx_err;
    assign cnt_clr = accept;
    assign det_clr = cmd_wr && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign ila_err = ila_q;

endmodule

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer
    import sdcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [15:0]      cmd_wdata,
    input  logic [31:0]      arg_wdata,
    input  logic [15:0]      card_rca,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             blk_done,
    output logic             frm_valid,
    input  logic             frm_ready,
    output logic [5:0]       frm_index,
    output logic [31:0]      frm_arg,
    output logic [2:0]       frm_rsp,
    output logic             frm_data,
    output logic             frm_read,
    output logic             frm_stop,
    input  logic             rsp_done,
    input  logic             rsp_timeout,
    input  logic             rsp_crc_err,
    input  logic             rsp_end_err,
    input  logic             rsp_idx_err,
    output logic             busy,
    output logic             ila_err,
    output logic [31:0]      err_detail
);

    cmd_desc_t desc;
    logic      illegal;
    logic      stop_hit;
    logic      cnt_clr, cnt_inc;
    logic      det_clr, det_upd, det_stop, crc_eff;

    sdcs_decode u_decode (
        .word    (cmd_wdata),
        .desc    (desc),
        .illegal (illegal)
    );

    sdcs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .desc_in     (desc),
        .illegal     (illegal),
        .arg_in      (arg_wdata),
        .card_rca    (card_rca),
        .frm_ready   (frm_ready),
        .rsp_done    (rsp_done),
        .rsp_timeout (rsp_timeout),
        .rsp_crc_err (rsp_crc_err),
        .rsp_end_err (rsp_end_err),
        .rsp_idx_err (rsp_idx_err),
        .stop_hit    (stop_hit),
        .blk_done    (blk_done),
        .frm_valid   (frm_valid),
        .frm_index   (frm_index),
        .frm_arg     (frm_arg),
        .frm_rsp     (frm_rsp),
        .frm_data    (frm_data),
        .frm_read    (frm_read),
        .frm_stop    (frm_stop),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .det_clr     (det_clr),
        .det_upd     (det_upd),
        .det_stop    (det_stop),
        .crc_eff     (crc_eff),
        .busy        (busy),
        .ila_err     (ila_err)
    );

    sdcs_blkcnt #(.CNT_W(CNT_W)) u_blkcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (blk_count),
        .hit   (stop_hit)
    );

    sdcs_errdet u_errdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (det_clr),
        .upd     (det_upd),
        .is_stop (det_stop),
        .tmo     (rsp_timeout),
        .crc     (crc_eff),
        .endb    (rsp_end_err),
        .idxe    (rsp_idx_err),
        .detail  (err_detail)
    );

endmodule

// File: rtl/sdcs_checker.sv
module sdcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        busy,
    input logic        ila_err,
    input logic        frm_valid,
    input logic        frm_ready,
    input logic [5:0]  frm_index,
    input logic [31:0] frm_arg,
    input logic [31:0] err_detail
);

    AST_FIXED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        err_detail[13]); // R10

    AST_UNUSED_DETAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err_detail & ~32'h0003_230F) == 32'h0); // R11

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr) |=> (err_detail == 32'h0000_2000)); // R10

    AST_BUSY_WRITE_ILA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ila_err); // R8

    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr)); // R13

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> busy); // R13

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=>
            (frm_valid && $stable(frm_index) && $stable(frm_arg))); // R14

endmodule

bind sd_cmd_sequencer sdcs_checker u_sdcs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .busy       (busy),
    .ila_err    (ila_err),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .frm_index  (frm_index),
    .frm_arg    (frm_arg),
    .err_detail (err_detail)
);

// File: tb/sd_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module sd_cmd_sequencer_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [15:0]      cmd_wdata = '0;
    logic [31:0]      arg_wdata = '0;
    logic [15:0]      card_rca = 16'hBEEF;
    logic [CNT_W-1:0] blk_count = '0;
    logic             blk_done = 1'b0;
    logic             frm_valid;
    logic             frm_ready = 1'b0;
    logic [5:0]       frm_index;
    logic [31:0]      frm_arg;
    logic [2:0]       frm_rsp;
    logic             frm_data, frm_read, frm_stop;
    logic             rsp_done = 1'b0;
    logic             rsp_timeout = 1'b0;
    logic             rsp_crc_err = 1'b0;
    logic             rsp_end_err = 1'b0;
    logic             rsp_idx_err = 1'b0;
    logic             busy, ila_err;
    logic [31:0]      err_detail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sd_cmd_sequencer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wdata(arg_wdata), .card_rca(card_rca), .blk_count(blk_count),
        .blk_done(blk_done), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_index(frm_index), .frm_arg(frm_arg), .frm_rsp(frm_rsp),
        .frm_data(frm_data), .frm_read(frm_read), .frm_stop(frm_stop),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
        .rsp_end_err(rsp_end_err), .rsp_idx_err(rsp_idx_err), .busy(busy),
        .ila_err(ila_err), .err_detail(err_detail)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [15:0] w, input logic [31:0] a);
        cmd_wdata = w;
        arg_wdata = a;
        cmd_wr    = 1'b1;
        tick();
        cmd_wr    = 1'b0;
    endtask

    // fl = {timeout, crc, end, index}
    task automatic serve(input string req, input logic [5:0] ei, input logic [31:0] ea,
                         input logic [2:0] er, input logic ed, input logic erd,
                         input logic es, input logic [3:0] fl);
        int n = 0;
        while (!frm_valid && n < 40) begin
            tick();
            n++;
        end
        chk(req, "frm_valid", 32'(frm_valid), 32'd1);
        chk(req, "frm_index", 32'(frm_index), 32'(ei));
        chk(req, "frm_arg", frm_arg, ea);
        chk(req, "frm_rsp", 32'(frm_rsp), 32'(er));
        chk(req, "frm_data/read/stop", {29'd0, frm_data, frm_read, frm_stop},
            {29'd0, ed, erd, es});
        tick();
        tick();
        chk("R14", "frame held", {25'd0, frm_valid, frm_index}, {25'd0, 1'b1, ei});
        frm_ready = 1'b1;
        tick();
        frm_ready = 1'b0;
        chk("R14", "valid drops after accept", 32'(frm_valid), 32'd0);
        {rsp_timeout, rsp_crc_err, rsp_end_err, rsp_idx_err} = fl;
        rsp_done = 1'b1;
        tick();
        rsp_done = 1'b0;
        {rsp_timeout, rsp_crc_err, rsp_end_err, rsp_idx_err} = 4'b0;
    endtask

    task automatic t_reset();
        chk("R2", "busy", 32'(busy), 32'd0);
        chk("R2", "frm_valid", 32'(frm_valid), 32'd0);
        chk("R2", "ila_err", 32'(ila_err), 32'd0);
        chk("R2", "err_detail", err_detail, 32'h0000_2000);
    endtask

    task automatic t_explicit();
        write_cmd(16'h040D, 32'h1234_5678);
        chk("R13", "busy after write", 32'(busy), 32'd1);
        serve("R1", 6'd13, 32'h1234_5678, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0);
        chk("R13", "busy after response", 32'(busy), 32'd0);
        write_cmd(16'h1C11, 32'h0000_0200);
        serve("R1", 6'd17, 32'h0000_0200, 3'd4, 1'b1, 1'b1, 1'b0, 4'b0);
        chk("R1", "single block ends", 32'(busy), 32'd0);
        chk("R1", "no errors", err_detail, 32'h0000_2000);
    endtask

    task automatic auto_case(input string req, input logic [15:0] w, input logic [5:0] ei,
                             input logic [2:0] er, input logic ed, input logic erd);
        write_cmd(w, 32'hA5A5_0000 | 32'(ei));
        serve(req, ei, 32'hA5A5_0000 | 32'(ei), er, ed, erd, 1'b0, 4'b0);
        chk(req, "idle after", 32'(busy), 32'd0);
    endtask

    task automatic t_auto();
        auto_case("R6", 16'h0000, 6'd0, 3'd3, 1'b0, 1'b0);
        auto_case("R6", 16'h0002, 6'd2, 3'd6, 1'b0, 1'b0);
        auto_case("R6", 16'h0009, 6'd9, 3'd6, 1'b0, 1'b0);
        auto_case("R6", 16'h0007, 6'd7, 3'd5, 1'b0, 1'b0);
        auto_case("R6", 16'h0011, 6'd17, 3'd4, 1'b1, 1'b1);
        auto_case("R6", 16'h0018, 6'd24, 3'd4, 1'b1, 1'b0);
        auto_case("R6", 16'h000D, 6'd13, 3'd4, 1'b0, 1'b0);
        auto_case("R7", 16'h380D, 6'd13, 3'd4, 1'b0, 1'b0);
    endtask

    task automatic t_acmd();
        write_cmd(16'h0069, 32'h40FF_8000);
        serve("R3", 6'd55, 32'hBEEF_0000, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0);
        chk("R13", "busy between prefix and main", 32'(busy), 32'd1);
        serve("R6", 6'd41, 32'h40FF_8000, 3'd7, 1'b0, 1'b0, 1'b0, 4'b0);
        chk("R13", "busy after acmd", 32'(busy), 32'd0);
    endtask

    task automatic t_prefix_err();
        int seen = 0;
        write_cmd(16'h0046, 32'h0000_0002);
        serve("R3", 6'd55, 32'hBEEF_0000, 3'd4, 1'b0, 1'b0, 1'b0, 4'b1000);
        for (int i = 0; i < 5; i++) begin
            if (frm_valid) seen++;
            tick();
        end
        chk("R4", "main frame not offered", 32'(seen), 32'd0);
        chk("R4", "busy", 32'(busy), 32'd0);
        chk("R11", "prefix timeout bit16", err_detail, 32'h0001_2000);
        write_cmd(16'h040D, 32'h0);
        chk("R10", "detail cleared on write", err_detail, 32'h0000_2000);
        serve("R1", 6'd13, 32'h0, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0);
    endtask

    task automatic t_multi();
        int seen = 0;
        blk_count = 16'd3;
        write_cmd(16'h0012, 32'h0000_1000);
        serve("R6", 6'd18, 32'h0000_1000, 3'd4, 1'b1, 1'b1, 1'b0, 4'b0);
        chk("R13", "busy during blocks", 32'(busy), 32'd1);
        for (int b = 0; b < 2; b++) begin
            blk_done = 1'b1;
            tick();
            blk_done = 1'b0;
            tick();
            if (frm_valid) seen++;
        end
        chk("R5", "no stop before count", 32'(seen), 32'd0);
        blk_done = 1'b1;
        tick();
        blk_done = 1'b0;
        chk("R5", "stop offered after last block", 32'(frm_valid), 32'd1);
        serve("R5", 6'd12, 32'h0, 3'd5, 1'b0, 1'b0, 1'b1, 4'b0);
        chk("R13", "idle after stop", 32'(busy), 32'd0);
        blk_count = 16'd0;
        write_cmd(16'h2C19, 32'h0000_0400);
        serve("R1", 6'd25, 32'h0000_0400, 3'd4, 1'b1, 1'b0, 1'b0, 4'b0);
        blk_done = 1'b1;
        tick();
        blk_done = 1'b0;
        serve("R5", 6'd12, 32'h0, 3'd5, 1'b0, 1'b0, 1'b1, 4'b1000);
        chk("R11", "stop timeout bit17", err_detail, 32'h0002_2000);
    endtask

    task automatic t_ila_busy();
        write_cmd(16'h040D, 32'h0000_0111);
        chk("R8", "ila clear after legal write", 32'(ila_err), 32'd0);
        write_cmd(16'h0403, 32'h0000_0222);
        chk("R8", "ila on busy write", 32'(ila_err), 32'd1);
        serve("R8", 6'd13, 32'h0000_0111, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0);
        chk("R8", "idle after original", 32'(busy), 32'd0);
    endtask

    task automatic combo(input logic [15:0] w);
        write_cmd(16'h040D, 32'h0);
        serve("R9", 6'd13, 32'h0, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0);
        write_cmd(w, 32'h0);
        chk("R9", "ila set", 32'(ila_err), 32'd1);
        chk("R9", "not started", {30'd0, busy, frm_valid}, 32'd0);
    endtask

    task automatic t_ila_combo();
        combo(16'h0B05);
        combo(16'h0C0C);
        combo(16'h0105);
        combo(16'h0205);
        combo(16'h0485);
        combo(16'h04C5);
    endtask

    task automatic t_errors();
        write_cmd(16'h0729, 32'h0);
        serve("R12", 6'd41, 32'h0, 3'd7, 1'b0, 1'b0, 1'b0, 4'b0100);
        chk("R12", "crc ignored for code 7", err_detail, 32'h0000_2000);
        write_cmd(16'h040D, 32'h0);
        serve("R11", 6'd13, 32'h0, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0100);
        chk("R11", "crc bit8", err_detail, 32'h0000_2100);
        write_cmd(16'h040D, 32'h0);
        serve("R11", 6'd13, 32'h0, 3'd4, 1'b0, 1'b0, 1'b0, 4'b0011);
        chk("R11", "end and index bits", err_detail, 32'h0000_2005);
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_explicit();
        t_auto();
        t_acmd();
        t_prefix_err();
        t_multi();
        t_ila_busy();
        t_ila_combo();
        t_errors();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule